// File: doc/BRIEF.md
# Row-Hit-First DRAM Command Scheduler

This block sits between a stream of memory requests and the command bus of a banked DRAM. Every request carries a bank, a row and a column. The block holds up to eight requests in a queue and keeps its own view of every bank: idle, or open with one row latched in the row buffer. Each cycle it places at most one command on the shared bus. The command is a precharge, an activate or a column access.

Open rows stay open after an access. The scheduler serves requests that hit an open row ahead of older requests that would first need a precharge and an activate. Each bank has its own down-counter that blocks new commands to that bank until the previous precharge or activate has finished.

A mode input switches the block to strict arrival order. In that mode only the oldest queued request may make progress. When a column access issues, the request leaves the queue and a one-cycle completion pulse carries the tag the request was given on arrival.

Top module: `dram_sched`

## Requirements
- R1: `req_ready` is high exactly while fewer than DEPTH (8) requests are queued. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Requests presented while the queue is full are held back by the handshake and are not lost.
- R2: Each bank is either idle or open on one row. Command codes on `cmd_op` are 0 none, 1 precharge, 2 activate, 3 column access. A precharge goes only to an open bank and leaves it idle. An activate goes only to an idle bank and opens `cmd_row`.
- R3: After a precharge or an activate, that bank receives no command for the next T_PRE-1 or T_ACT-1 cycles (2 with the defaults). After a column access, the bank may be commanded again in the very next cycle.
- R4: A request whose row is open in its bank needs only a column access. A request to a different row gets a precharge, then an activate, then a column access. Every column access names the row that is open in its bank.
- R5: Rows stay open after a column access. A later request to the same row of that bank is served with no further precharge or activate.
- R6: With `fifo_mode` low, each bank serves its oldest queued row hit before any older request that misses the row. If a bank has no hit, its oldest request goes next.
- R7: With `fifo_mode` high, only the oldest queued request may receive commands, so requests complete strictly in arrival order.
- R8: At most one command issues per cycle. When several banks can take a command, a bank with a column access ready wins over banks that need a precharge or activate. Within each class, the lowest-numbered bank wins.
- R9: `done_valid` pulses in exactly the cycle of a request's column access, and that request's queue slot is freed in the same cycle. `done_tag` equals the request's arrival count since reset, modulo 8.
- R10: For a fixed 8-request, 2-bank trace with alternating rows, the time to complete all requests is longer with `fifo_mode` high than with it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_mode | input | 1 | 1: strict arrival order; 0: row-hit-first |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue has room |
| req_bank | input | log2(NBANK) | Request bank |
| req_row | input | ROW_W | Request row |
| req_col | input | COL_W | Request column |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_op | output | 2 | 1 precharge, 2 activate, 3 column access |
| cmd_bank | output | log2(NBANK) | Command bank |
| cmd_row | output | ROW_W | Row being opened, accessed or closed |
| cmd_col | output | COL_W | Column of a column access |
| done_valid | output | 1 | Request completed this cycle |
| done_tag | output | log2(DEPTH) | Tag of the completed request |

## Verification
The bench builds the block with NBANK=2, ROW_W=4 and COL_W=4, and keeps DEPTH=8 and both latencies at 3. With only two banks, one 8-request trace that alternates rows in both banks produces hits, misses, cross-bank contention and reordering. That same trace can be timed in both modes. The queue depth of 8 lets a back-to-back burst to one bank with alternating rows fill the queue quickly, which tests back-pressure and wrap-around of the tag counter.

// File: rtl/dram_sched.sv
module dram_sched #(
  parameter int NBANK = 4,
  parameter int ROW_W = 14,
  parameter int COL_W = 10,
  parameter int DEPTH = 8,
  parameter int T_PRE = 3,
  parameter int T_ACT = 3
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 fifo_mode,
  input  logic                                 req_valid,
  output logic                                 req_ready,
  input  logic [(NBANK>1?$clog2(NBANK):1)-1:0] req_bank,
  input  logic [ROW_W-1:0]                     req_row,
  input  logic [COL_W-1:0]                     req_col,
  output logic                                 cmd_valid,
  output logic [1:0]                           cmd_op,
  output logic [(NBANK>1?$clog2(NBANK):1)-1:0] cmd_bank,
  output logic [ROW_W-1:0]                     cmd_row,
  output logic [COL_W-1:0]                     cmd_col,
  output logic                                 done_valid,
  output logic [(DEPTH>1?$clog2(DEPTH):1)-1:0] done_tag
);
  localparam int BW = NBANK > 1 ? $clog2(NBANK) : 1;
  localparam int QW = DEPTH > 1 ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int TM = T_PRE > T_ACT ? T_PRE : T_ACT;
  localparam int TW = $clog2(TM + 1);
  localparam logic [1:0] OP_PRE = 2'd1, OP_ACT = 2'd2, OP_COL = 2'd3;

  logic [BW-1:0]    q_bank [DEPTH], n_bank [DEPTH];
  logic [ROW_W-1:0] q_row  [DEPTH], n_row  [DEPTH];
  logic [COL_W-1:0] q_col  [DEPTH], n_col  [DEPTH];
  logic [QW-1:0]    q_tag  [DEPTH], n_tag  [DEPTH];
  logic [CW-1:0]    count, wpos;
  logic [QW-1:0]    tag_ctr;

  logic [NBANK-1:0] bank_open;
  logic [ROW_W-1:0] open_row [NBANK];
  logic [TW-1:0]    timer    [NBANK];

  logic [NBANK-1:0] b_ok, b_hit;
  logic [QW-1:0]    b_idx [NBANK];
  logic             win_f, retire, accept;
  logic [BW-1:0]    win_b;
  logic [QW-1:0]    w_idx;

  always_comb begin
    for (int b = 0; b < NBANK; b++) begin
      logic any_f, hit_f;
      logic [QW-1:0] any_i, hit_i;
      any_f = 1'b0; hit_f = 1'b0; any_i = '0; hit_i = '0;
      for (int i = 0; i < DEPTH; i++) begin
        if (CW'(i) < count && q_bank[i] == BW'(b) && (!fifo_mode || i == 0)) begin
          if (!any_f) begin any_f = 1'b1; any_i = QW'(i); end
          if (!hit_f && bank_open[b] && q_row[i] == open_row[b]) begin
            hit_f = 1'b1; hit_i = QW'(i);
          end
        end
      end
      b_ok[b]  = any_f && timer[b] == '0;
      b_hit[b] = hit_f;
      b_idx[b] = hit_f ? hit_i : any_i;
    end
  end

  always_comb begin
    win_f = 1'b0; win_b = '0;
    for (int b = 0; b < NBANK; b++)
      if (!win_f && b_ok[b] && b_hit[b]) begin win_f = 1'b1; win_b = BW'(b); end
    for (int b = 0; b < NBANK; b++)
      if (!win_f && b_ok[b]) begin win_f = 1'b1; win_b = BW'(b); end
  end

  assign w_idx      = b_idx[win_b];
  assign cmd_valid  = win_f;
  assign cmd_op     = !win_f ? 2'd0 : b_hit[win_b] ? OP_COL : bank_open[win_b] ? OP_PRE : OP_ACT;
  assign cmd_bank   = win_b;
  assign cmd_row    = cmd_op == OP_PRE ? open_row[win_b] : q_row[w_idx];
  assign cmd_col    = q_col[w_idx];
  assign retire     = cmd_op == OP_COL;
  assign done_valid = retire;
  assign done_tag   = q_tag[w_idx];
  assign req_ready  = count < CW'(DEPTH);
  assign accept     = req_valid && req_ready;
  assign wpos       = count - CW'(retire);

  always_comb begin
    n_bank = q_bank; n_row = q_row; n_col = q_col; n_tag = q_tag;
    if (retire)
      for (int i = 0; i < DEPTH - 1; i++)
        if (QW'(i) >= w_idx) begin
          n_bank[i] = q_bank[i+1]; n_row[i] = q_row[i+1];
          n_col[i]  = q_col[i+1];  n_tag[i] = q_tag[i+1];
        end
    if (accept) begin
      n_bank[wpos[QW-1:0]] = req_bank; n_row[wpos[QW-1:0]] = req_row;
      n_col[wpos[QW-1:0]]  = req_col;  n_tag[wpos[QW-1:0]] = tag_ctr;
    end
  end

  always_ff @(posedge clk) begin
    q_bank <= n_bank; q_row <= n_row; q_col <= n_col; q_tag <= n_tag;
    if (!rst_n) begin
      count     <= '0;
      tag_ctr   <= '0;
      bank_open <= '0;
      for (int b = 0; b < NBANK; b++) begin
        timer[b]    <= '0;
        open_row[b] <= '0;
      end
    end else begin
      count   <= count + CW'(accept) - CW'(retire);
      tag_ctr <= tag_ctr + QW'(accept);
      for (int b = 0; b < NBANK; b++) begin
        if (timer[b] != '0) timer[b] <= timer[b] - 1'b1;
        if (win_f && win_b == BW'(b)) begin
          if (cmd_op == OP_PRE) begin
            bank_open[b] <= 1'b0;
            timer[b]     <= TW'(T_PRE - 1);
          end else if (cmd_op == OP_ACT) begin
            bank_open[b] <= 1'b1;
            open_row[b]  <= q_row[w_idx];
            timer[b]     <= TW'(T_ACT - 1);
          end
        end
      end
    end
  end

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> count <= $past(count));
  assert_act_to_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_op == OP_ACT |-> !bank_open[cmd_bank]);
  assert_pre_to_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_op == OP_PRE |-> bank_open[cmd_bank]);
  assert_pre_gap1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_op == OP_PRE |=> !(cmd_valid && cmd_bank == $past(cmd_bank)));
  assert_act_gap1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_op == OP_ACT |=> !(cmd_valid && cmd_bank == $past(cmd_bank)));
  assert_act_gap2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_op == OP_ACT |-> ##2 !(cmd_valid && cmd_bank == $past(cmd_bank, 2)));
  assert_col_open_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_op == OP_COL |-> bank_open[cmd_bank] && open_row[cmd_bank] == cmd_row);
  assert_retire_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && !accept |=> count == $past(count) - 1'b1);
endmodule

// File: tb/tb_dram_sched.sv
module tb_dram_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 2, RW = 4, CWD = 4;

  logic clk = 0, rst_n = 0, fifo_mode = 0, req_valid = 0;
  logic req_ready, cmd_valid, done_valid;
  logic [0:0] req_bank = '0, cmd_bank;
  logic [RW-1:0] req_row = '0, cmd_row;
  logic [CWD-1:0] req_col = '0, cmd_col;
  logic [1:0] cmd_op;
  logic [2:0] done_tag;

  dram_sched #(.NBANK(NB), .ROW_W(RW), .COL_W(CWD)) dut (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .req_valid(req_valid),
    .req_ready(req_ready), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .cmd_col(cmd_col), .done_valid(done_valid), .done_tag(done_tag));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, last_done = 0, full_seen = 0;
  int n_pre = 0, n_act = 0, tag = 0;
  bit auto_exp = 1, finished = 0;
  int exp_q[$];
  bit m_open [NB];
  int m_row [NB], last_cyc [NB], need [NB];

  task automatic check(input bit ok, input string rq, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", rq, act, expv);
    end
  endtask

  // monitor: bank model, timing rules and scoreboard of completions
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin
        m_open[b] = 0; m_row[b] = 0; last_cyc[b] = -100; need[b] = 0;
      end
    end else begin
      if (cmd_valid) begin
        int b;
        b = int'(cmd_bank);
        check(cyc - last_cyc[b] >= need[b], "R3 bank busy window", cyc - last_cyc[b], need[b]);
        case (cmd_op)
          2'd1: begin
            check(m_open[b], "R2 precharge needs open bank", int'(m_open[b]), 1);
            m_open[b] = 0; need[b] = 3; n_pre++;
          end
          2'd2: begin
            check(!m_open[b], "R2 activate needs idle bank", int'(m_open[b]), 0);
            m_open[b] = 1; m_row[b] = int'(cmd_row); need[b] = 3; n_act++;
          end
          default: begin
            check(m_open[b] && m_row[b] == int'(cmd_row), "R4 column access to open row",
                  int'(cmd_row), m_row[b]);
            check(done_valid, "R9 completion with column access", int'(done_valid), 1);
            need[b] = 1;
          end
        endcase
        last_cyc[b] = cyc;
      end
      if (done_valid) begin
        last_done = cyc;
        if (exp_q.size() == 0) check(0, "R9 unexpected completion", int'(done_tag), -1);
        else begin
          int e;
          e = exp_q.pop_front();
          check(int'(done_tag) == e, "R6 R7 R8 R9 completion order/tag", int'(done_tag), e);
        end
      end
    end
  end

  task automatic do_reset(input bit fm);
    @(negedge clk);
    rst_n = 0; req_valid = 0; fifo_mode = fm;
    repeat (2) @(negedge clk);
    check(req_ready == 1, "R1 reset ready", int'(req_ready), 1);
    check(cmd_valid == 0, "R8 reset no command", int'(cmd_valid), 0);
    check(done_valid == 0, "R9 reset no completion", int'(done_valid), 0);
    rst_n = 1; tag = 0; n_pre = 0; n_act = 0; full_seen = 0;
    exp_q.delete();
  endtask

  // driver: called at a negedge, returns at the next negedge after transfer
  task automatic push(input int b, input int r, input int c);
    req_valid = 1; req_bank = 1'(b); req_row = RW'(r); req_col = CWD'(c);
    while (!req_ready) begin full_seen++; @(negedge clk); end
    if (auto_exp) exp_q.push_back(tag % 8);
    tag++;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic push_trace();
    push(0, 0, 0); push(0, 1, 0); push(0, 0, 1); push(0, 1, 3);
    push(1, 0, 0); push(1, 1, 1); push(1, 0, 0); push(1, 1, 2);
  endtask

  task automatic drain();
    int t = 0;
    while (exp_q.size() != 0 && t < 2000) begin @(negedge clk); t++; end
    check(exp_q.size() == 0, "R9 all requests completed", exp_q.size(), 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int start, fr_total, fifo_total;
    // row-hit-first on the trace
    do_reset(0);
    auto_exp = 0;
    exp_q = '{0, 2, 4, 6, 1, 3, 5, 7};
    start = cyc;
    push_trace();
    drain();
    fr_total = last_done - start;
    check(n_act == 4, "R5 activates with rows kept open", n_act, 4);
    check(n_pre == 2, "R5 precharges with rows kept open", n_pre, 2);

    // strict arrival order on the same trace
    do_reset(1);
    auto_exp = 1;
    start = cyc;
    push_trace();
    drain();
    fifo_total = last_done - start;
    check(n_act == 8, "R7 activates in arrival order", n_act, 8);
    check(n_pre == 6, "R7 precharges in arrival order", n_pre, 6);
    check(fifo_total > fr_total, "R10 arrival order slower", fifo_total, fr_total + 1);

    // back-pressure and tag wrap: ten same-bank requests, alternating rows
    do_reset(1);
    for (int i = 0; i < 10; i++) push(0, i % 2, i);
    drain();
    check(full_seen > 0, "R1 ready low when queue full", full_seen, 1);
    check(tag == 10, "R1 all requests accepted", tag, 10);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule